// File: doc/BRIEF.md
# Byte-Wide SPI Shift Engine with Abort and Mode Fault

This block moves 8-bit words across a serial link, in either master or slave role. Words come from an external transmit queue through a peek/commit pair. The engine reads the head word from `tx_data` while `tx_valid` is high. It pulses `tx_commit` only when that word has fully left the shifter. Each completed transfer hands its received word to an external receive queue. If that queue reports full, the word is discarded and a one-cycle overflow pulse is raised instead.

In master mode the engine makes its own serial clock by dividing the system clock. It runs SPI mode 0 (clock idles low, data sampled on the rising edge, changed on the falling edge) and sends the MSB first. Raising `inhibit` cuts a running master transfer short. The word stays at the head of the queue, so the same word goes out again once `inhibit` drops. A loop control routes the outgoing bit straight into the receive shifter. If another master pulls this device's select line while it is a master, the engine releases its output drivers at once, aborts, and latches a fault flag. A status read clears that flag. Master transfers stay blocked until `en` is taken low and then high again. In slave mode the engine follows an external clock while its select line is low.

Top module: `spi_engine`

## Requirements
- R1: While `rst_n` is low, `sck_o`, `tx_commit`, `rx_push`, `rx_ovf` and `fault` are all 0.
- R2: A master transfer begins on the first clock edge at which `master`, `en` and `tx_valid` are high, `inhibit` is low and no fault lockout is active. It shifts `tx_data` out on `sdo` MSB first, with `sck_o` idling low and each SCK half period lasting HALF_DIV clocks. `tx_commit` pulses for one cycle, after the edge that falls 16*HALF_DIV clock edges after the start edge.
- R3: Words queued while `en` is low produce no SCK activity and no results. Once `en` rises they are sent one after another until `tx_valid` is low.
- R4: At the end of every transfer, if `rx_full` is low, the 8 bits received (the first-received bit is bit 7) appear on `rx_data` with a one-cycle `rx_push` pulse. This happens in the same cycle as `tx_commit`.
- R5: If `rx_full` is high at the end of a transfer, the received word is dropped. `rx_push` stays low, `rx_ovf` pulses for one cycle, and the transmit word is still committed.
- R6: `inhibit` high during a master transfer aborts it on the next edge. `sck_o` returns low, and there is no `tx_commit` and no `rx_push`. The same word is sent in full once `inhibit` is low again.
- R7: `inhibit` has no effect in slave mode: the slave transfer completes and delivers its word.
- R8: With `loop` high in master mode, the received word equals the transmitted word, whatever is on `sdi`.
- R9: When `master` and `en` are high and `ss_n_in` goes low, `sck_oe` and `sdo_oe` drop in the same cycle. `fault` is 1 after the next edge, and any running transfer is aborted without commit.
- R10: `stat_rd` high for one edge clears `fault`, unless the fault condition is present at that same edge.
- R11: After a mode fault, no master transfer starts until `en` has been low for at least one edge and then high again.
- R12: In slave mode, while `en` is high, `ss_n_in` is low and a word is queued, the engine shifts on `sck_in`. It samples `sdi` on rising edges, advances `sdo` on falling edges, and completes after 8 falling edges. `loop` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Engine enable |
| master | input | 1 | 1 = master role, 0 = slave role |
| inhibit | input | 1 | Master transaction inhibit / abort |
| loop | input | 1 | Internal loopback in master role |
| stat_rd | input | 1 | Status read strobe, clears the fault flag |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 8 | Head word of the transmit queue |
| tx_commit | output | 1 | Pop the head word (transfer finished) |
| rx_full | input | 1 | Receive queue is full |
| rx_push | output | 1 | Write `rx_data` into the receive queue |
| rx_data | output | 8 | Received word |
| rx_ovf | output | 1 | Received word dropped, queue full |
| fault | output | 1 | Mode-fault status flag |
| ss_n_in | input | 1 | Slave-select input, active low |
| sck_in | input | 1 | Serial clock input (slave role) |
| sdi | input | 1 | Serial data input |
| sck_o | output | 1 | Serial clock output (master role) |
| sck_oe | output | 1 | Drive enable for `sck_o` |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Drive enable for `sdo` |

## Verification
A master transfer's result pulses are due exactly 1 + 16*HALF_DIV clock edges after the input edge at which the queued word first becomes visible. The bench counts edges from that point and demands the pulse on exactly that count. The drive-enable drop on a mode fault is combinational, so it is sampled a few time units after the select change, before any clock edge. The fault flag and its clearing are sampled one edge later. Slave-side results are checked two cycles after the eighth falling `sck_in`. Abort and lockout cases are judged over windows longer than a full transfer, so that any stray result would have had time to appear.

// File: rtl/spi_engine.sv
module spi_engine #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       master,
  input  logic       inhibit,
  input  logic       loop,
  input  logic       stat_rd,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_commit,
  input  logic       rx_full,
  output logic       rx_push,
  output logic [7:0] rx_data,
  output logic       rx_ovf,
  output logic       fault,
  input  logic       ss_n_in,
  input  logic       sck_in,
  input  logic       sdi,
  output logic       sck_o,
  output logic       sck_oe,
  output logic       sdo,
  output logic       sdo_oe
);
  localparam int CW = $clog2(HALF_DIV + 1);

  logic          busy, sck_r, sck_q, lock;
  logic [CW-1:0] div_cnt;
  logic [2:0]    bitn;
  logic [7:0]    tx_sh, rx_sh;

  wire collide = master & en & ~ss_n_in;
  wire slv_sel = ~master & en & ~ss_n_in;
  wire m_ok    = master & en & ~lock & ss_n_in;
  wire tick    = div_cnt == CW'(HALF_DIV - 1);
  wire in_bit  = (master & loop) ? tx_sh[7] : sdi;
  wire rise    = master ? (tick & ~sck_r) : (sck_in & ~sck_q);
  wire fall    = master ? (tick & sck_r)  : (~sck_in & sck_q);
  wire abort   = master ? (inhibit | ~m_ok) : ~slv_sel;
  wire start   = ~busy & tx_valid & (master ? (m_ok & ~inhibit) : slv_sel);

  assign sck_o  = sck_r;
  assign sck_oe = m_ok;
  assign sdo    = tx_sh[7];
  assign sdo_oe = m_ok | slv_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;  sck_r <= 1'b0;  sck_q <= 1'b0;
      lock <= 1'b0;  fault <= 1'b0;  div_cnt <= '0;
      bitn <= '0;    tx_sh <= '0;    rx_sh <= '0;
      rx_data <= '0; tx_commit <= 1'b0;
      rx_push <= 1'b0; rx_ovf <= 1'b0;
    end else begin
      tx_commit <= 1'b0;
      rx_push   <= 1'b0;
      rx_ovf    <= 1'b0;
      sck_q     <= sck_in;

      if (collide)      fault <= 1'b1;
      else if (stat_rd) fault <= 1'b0;
      if (collide)      lock <= 1'b1;
      else if (!en)     lock <= 1'b0;

      if (busy) begin
        if (abort) begin
          busy    <= 1'b0;
          sck_r   <= 1'b0;
          div_cnt <= '0;
        end else begin
          if (master) begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick) sck_r <= ~sck_r;
          end
          if (rise) rx_sh <= {rx_sh[6:0], in_bit};
          if (fall) begin
            tx_sh <= {tx_sh[6:0], 1'b0};
            bitn  <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              busy      <= 1'b0;
              tx_commit <= 1'b1;
              rx_data   <= rx_sh;
              if (rx_full) rx_ovf  <= 1'b1;
              else         rx_push <= 1'b1;
            end
          end
        end
      end else if (start) begin
        busy    <= 1'b1;
        tx_sh   <= tx_data;
        bitn    <= '0;
        div_cnt <= '0;
        sck_r   <= 1'b0;
      end
    end
  end
endmodule

module spi_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic master,
  input logic en,
  input logic inhibit,
  input logic ss_n_in,
  input logic stat_rd,
  input logic rx_full,
  input logic tx_commit,
  input logic rx_push,
  input logic rx_ovf,
  input logic fault,
  input logic lock
);
  a_r4_commit_has_result: assert property (@(posedge clk) disable iff (!rst_n)
    tx_commit |-> (rx_push || rx_ovf));

  a_r5_full_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !$past(rx_full));

  a_r6_inhibit_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (master && inhibit) |=> !tx_commit);

  a_r9_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (master && en && !ss_n_in) |=> fault);

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(master && en && !ss_n_in)) |=> !fault);

  a_r11_locked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && master) |=> !tx_commit);
endmodule

bind spi_engine spi_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .en(en), .inhibit(inhibit),
  .ss_n_in(ss_n_in), .stat_rd(stat_rd), .rx_full(rx_full),
  .tx_commit(tx_commit), .rx_push(rx_push), .rx_ovf(rx_ovf),
  .fault(fault), .lock(lock)
);

// File: tb/spi_engine_tb.sv
`timescale 1ns/1ps
module spi_engine_tb;
  localparam int HD = 2;
  localparam int XFER = 1 + 16 * HD;

  logic clk = 0, rst_n = 0;
  logic en = 0, master = 1, inhibit = 0, loop = 0, stat_rd = 0;
  logic rx_full = 0, ss_n_in = 1, sck_in = 0, s_sdi = 0;
  logic tx_commit, rx_push, rx_ovf, fault, sck_o, sck_oe, sdo, sdo_oe, sdi;
  logic [7:0] rx_data, tx_data;
  logic [7:0] q [8];
  logic [3:0] head = 0, tail = 0;
  logic [7:0] sl_reg = 0, mo_cap = 0;
  logic [7:0] rxq [32];
  int nrx = 0, novf = 0, sck_rises = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  wire tx_valid = head != tail;
  assign tx_data = q[head[2:0]];
  assign sdi = master ? sl_reg[7] : s_sdi;

  spi_engine #(.HALF_DIV(HD)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .master(master), .inhibit(inhibit),
    .loop(loop), .stat_rd(stat_rd), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_commit(tx_commit), .rx_full(rx_full), .rx_push(rx_push),
    .rx_data(rx_data), .rx_ovf(rx_ovf), .fault(fault), .ss_n_in(ss_n_in),
    .sck_in(sck_in), .sdi(sdi), .sck_o(sck_o), .sck_oe(sck_oe), .sdo(sdo),
    .sdo_oe(sdo_oe));

  always @(negedge clk) begin
    if (tx_commit) head <= head + 1'b1;
    if (rx_push) begin rxq[nrx[4:0]] <= rx_data; nrx <= nrx + 1; end
    if (rx_ovf) novf <= novf + 1;
  end
  always @(posedge sck_o) begin mo_cap <= {mo_cap[6:0], sdo}; sck_rises <= sck_rises + 1; end
  always @(negedge sck_o) sl_reg <= {sl_reg[6:0], 1'b0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask
  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic put(input logic [7:0] b); q[tail[2:0]] = b; tail = tail + 1'b1; endtask

  // {loop, tx, remote}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 8'hA5, 8'h3C}, {1'b0, 8'h00, 8'hFF}, {1'b0, 8'hFF, 8'h00},
    {1'b1, 8'h81, 8'h7E}, {1'b1, 8'h5A, 8'hFF}, {1'b0, 8'h80, 8'h01}};

  initial begin
    cyc(3);
    chk(sck_o == 0 && !tx_commit && !rx_push && !rx_ovf && !fault, "R1 reset", {sck_o, fault}, 0);
    rst_n = 1; en = 1; master = 1;
    cyc(2);

    foreach (VEC[i]) begin
      int n0, cnt;
      logic [7:0] exp;
      loop = VEC[i][16]; sl_reg = VEC[i][7:0]; mo_cap = 0; n0 = nrx; cnt = 0;
      exp = loop ? VEC[i][15:8] : VEC[i][7:0];
      put(VEC[i][15:8]);
      do begin @(negedge clk); cnt++; end while (!rx_push && cnt < 200);
      chk(cnt == XFER, "R2 result cycle", cnt, XFER);
      chk(rx_data == exp, loop ? "R8 loopback word" : "R4 received word", rx_data, exp);
      cyc(1);
      chk(mo_cap == VEC[i][15:8], "R2 sdo bits msb first", mo_cap, VEC[i][15:8]);
      chk(!tx_valid, "R2 word committed", tx_valid, 0);
    end

    begin : r3_deferred
      int n0, s0;
      en = 0; loop = 1; n0 = nrx; s0 = sck_rises;
      put(8'h11); put(8'h22); put(8'h33);
      cyc(40);
      chk(sck_rises == s0 && nrx == n0, "R3 idle while disabled", sck_rises - s0, 0);
      en = 1;
      cyc(3 * (XFER + 2) + 10);
      chk(nrx == n0 + 3, "R3 burst count", nrx - n0, 3);
      chk(rxq[n0[4:0]] == 8'h11 && rxq[5'(n0 + 1)] == 8'h22 && rxq[5'(n0 + 2)] == 8'h33,
          "R3 burst order", rxq[5'(n0 + 2)], 8'h33);
      chk(!tx_valid, "R3 queue drained", tx_valid, 0);
    end

    begin : r6_abort
      int n0;
      loop = 0; sl_reg = 8'hC3; n0 = nrx;
      put(8'h96);
      cyc(10); inhibit = 1; cyc(2);
      chk(sck_o == 0, "R6 sck low after abort", sck_o, 0);
      cyc(40);
      chk(nrx == n0 && tx_valid, "R6 no commit on abort", nrx - n0, 0);
      sl_reg = 8'hC3; mo_cap = 0; inhibit = 0;
      cyc(XFER + 5);
      chk(nrx == n0 + 1 && rxq[n0[4:0]] == 8'hC3, "R6 retry result", rxq[n0[4:0]], 8'hC3);
      chk(mo_cap == 8'h96, "R6 retry resends word", mo_cap, 8'h96);
    end

    begin : r5_overflow
      int n0, o0;
      loop = 1; rx_full = 1; n0 = nrx; o0 = novf;
      put(8'h44);
      cyc(XFER + 5);
      chk(nrx == n0 && novf == o0 + 1, "R5 dropped with overflow", novf - o0, 1);
      chk(!tx_valid, "R5 word still committed", tx_valid, 0);
      rx_full = 0;
    end

    begin : r9_fault
      int n0, s0;
      n0 = nrx;
      put(8'h77);
      cyc(10); ss_n_in = 0; #1;
      chk(!sck_oe && !sdo_oe, "R9 drivers released", {sck_oe, sdo_oe}, 0);
      cyc(1);
      chk(fault == 1, "R9 fault flag set", fault, 1);
      ss_n_in = 1;
      cyc(40);
      chk(nrx == n0 && tx_valid, "R9 transfer aborted", nrx - n0, 0);
      stat_rd = 1; cyc(1); stat_rd = 0; cyc(1);
      chk(fault == 0, "R10 read clears fault", fault, 0);
      s0 = sck_rises;
      cyc(50);
      chk(nrx == n0 && sck_rises == s0, "R11 locked until re-enable", sck_rises - s0, 0);
      en = 0; cyc(1); en = 1;
      cyc(XFER + 5);
      chk(nrx == n0 + 1 && rxq[n0[4:0]] == 8'h77, "R11 runs after re-enable", rxq[n0[4:0]], 8'h77);
    end

    begin : r12_slave
      int n0;
      logic [7:0] cap, din;
      master = 0; inhibit = 1; loop = 1; n0 = nrx; din = 8'h5B; cap = 0;
      put(8'hA6);
      ss_n_in = 0; cyc(2);
      for (int b = 7; b >= 0; b--) begin
        s_sdi = din[b]; cap = {cap[6:0], sdo}; sck_in = 1; cyc(2);
        sck_in = 0; cyc(2);
      end
      chk(nrx == n0 + 1 && rxq[n0[4:0]] == din, "R7 inhibit ignored in slave", rxq[n0[4:0]], din);
      chk(cap == 8'hA6, "R12 slave sdo bits", cap, 8'hA6);
      ss_n_in = 1; inhibit = 0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule